// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block watches the four active-low modem handshake lines of one serial channel: clear-to-send, data-set-ready, ring indicator and carrier detect. Software reads them as one 8-bit status word. The upper nibble holds the current asserted state of each line. The lower nibble holds sticky change flags. While any flag is set and the interrupt enable is high, the block requests a modem-status interrupt.

In loopback mode the state bits come from four modem-control outputs of the same channel instead of from the pins. This lets software test its handshake paths without a cable. Each change flag has its own rule. Ring indicator records only its rising state edge. The other three lines record a change in either direction. A read strobe returns the current word and clears every flag at the clock edge that ends the read. An edge seen in that same cycle is not lost.

Top module: `modem_stat_reg`

## Requirements
- R1: With loopback off, one clock edge after the pins are sampled, bit 7 = NOT carrier-detect pin, bit 6 = NOT ring pin, bit 5 = NOT data-set-ready pin and bit 4 = NOT clear-to-send pin.
- R2: With loopback on, one edge later, bit 4 = `ctl_rts`, bit 5 = `ctl_dtr`, bit 6 = `ctl_aux1` and bit 7 = `ctl_aux2`, whatever the pins are.
- R3: Bit 0 (clear-to-send) and bit 1 (data-set-ready) are set when their state bit (4 or 5) changes in either direction.
- R4: Bit 2 (ring) is set only when state bit 6 goes from 0 to 1. A 1 to 0 transition of bit 6 leaves bit 2 unchanged.
- R5: Bit 3 (carrier) is set when state bit 7 changes in either direction.
- R6: Change flags stay set until a read. The word presented during a cycle with `stat_rd` high is the pre-clear value, and after that edge bits 3..0 are 0 unless R7 applies.
- R7: A change flag whose event occurs in the same cycle as a read is set after that edge.
- R8: `irq` is high exactly when `irq_en` is high and at least one of bits 3..0 is set.
- R9: While reset is active, and with idle (high) pins after its release, `stat_q` is 0x00 and `irq` is 0.
- R10: Switching loopback on or off raises the change flags of every state bit whose selected source differs from the previous state, following R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_cts_n | input | 1 | Clear-to-send line, active low, already synchronized |
| line_dsr_n | input | 1 | Data-set-ready line, active low, already synchronized |
| line_ri_n | input | 1 | Ring indicator line, active low, already synchronized |
| line_dcd_n | input | 1 | Carrier detect line, active low, already synchronized |
| lpbk_en | input | 1 | Loopback mode select |
| ctl_rts | input | 1 | Modem-control request-to-send bit, feeds bit 4 in loopback |
| ctl_dtr | input | 1 | Modem-control terminal-ready bit, feeds bit 5 in loopback |
| ctl_aux1 | input | 1 | Modem-control auxiliary output 1, feeds bit 6 in loopback |
| ctl_aux2 | input | 1 | Modem-control auxiliary output 2, feeds bit 7 in loopback |
| stat_rd | input | 1 | Read strobe. Flags clear at the edge that ends this cycle |
| irq_en | input | 1 | Modem-status interrupt enable |
| stat_q | output | 8 | Status word: bits 7..4 state, bits 3..0 change flags |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A wrong previous-state register shows up as a missing or spurious change flag on `stat_q[3:0]` one edge after the line moves. It also shows in `irq` in the same cycle, because `irq` is combinational from the flags. A wrong flag register shows at the latest at the next read. Either a cleared flag survives, or a flag set in the read cycle disappears. The bench drives a reference model of every requirement alongside the design and compares the whole word and `irq` after every edge. That means a divergence is reported in the first cycle it exists.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NSIG    = 4;
  localparam int STAT_W  = 2 * NSIG;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/msr_rst_sync.sv
module msr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel #(
  parameter int W = 4
) (
  input  logic         lpbk_en,
  input  logic [W-1:0] pins_n,
  input  logic [W-1:0] ctl_bits,
  output logic [W-1:0] state_sel
);
  always_comb begin
    if (lpbk_en) state_sel = ctl_bits;
    else         state_sel = ~pins_n;
  end
endmodule

// File: rtl/msr_change_flag.sv
module msr_change_flag
  import msr_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic clr,
  output logic flag
);
  logic hit;
  logic flag_q;
  logic flag_d;

  generate
    if (MODE == EDGE_RISE) begin : g_rise
      assign hit = cur & ~prev;
    end else begin : g_any
      assign hit = cur ^ prev;
    end
  endgenerate

  always_comb begin
    flag_d = (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/modem_stat_reg.sv
module modem_stat_reg
  import msr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_cts_n,
  input  logic              line_dsr_n,
  input  logic              line_ri_n,
  input  logic              line_dcd_n,
  input  logic              lpbk_en,
  input  logic              ctl_rts,
  input  logic              ctl_dtr,
  input  logic              ctl_aux1,
  input  logic              ctl_aux2,
  input  logic              stat_rd,
  input  logic              irq_en,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  logic            rst_int_n;
  logic [NSIG-1:0] pins_n;
  logic [NSIG-1:0] ctl_bits;
  logic [NSIG-1:0] state_sel;
  logic [NSIG-1:0] state_q;
  logic [NSIG-1:0] state_d;
  logic [NSIG-1:0] flags;

  msr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign pins_n   = {line_dcd_n, line_ri_n, line_dsr_n, line_cts_n};
  assign ctl_bits = {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts};

  msr_src_sel #(.W(NSIG)) u_sel (
    .lpbk_en   (lpbk_en),
    .pins_n    (pins_n),
    .ctl_bits  (ctl_bits),
    .state_sel (state_sel)
  );

  always_comb begin
    state_d = state_sel;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= '0;
    else            state_q <= state_d;
  end

  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_flag
      localparam edge_mode_e MODE_I = (i == IDX_RI) ? EDGE_RISE : EDGE_ANY;
      msr_change_flag #(.MODE(MODE_I)) u_flag (
        .clk   (clk),
        .rst_n (rst_int_n),
        .cur   (state_sel[i]),
        .prev  (state_q[i]),
        .clr   (stat_rd),
        .flag  (flags[i])
      );
    end
  endgenerate

  assign stat_q = {state_q, flags};
  assign irq    = irq_en & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst_int_n,
  input logic       line_cts_n,
  input logic       line_dsr_n,
  input logic       line_ri_n,
  input logic       line_dcd_n,
  input logic       lpbk_en,
  input logic       ctl_rts,
  input logic       ctl_dtr,
  input logic       ctl_aux1,
  input logic       ctl_aux2,
  input logic       stat_rd,
  input logic       irq_en,
  input logic [7:0] stat_q,
  input logic       irq
);
  assert_pin_state_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lpbk_en |=> (stat_q[7:4] == ~$past({line_dcd_n, line_ri_n, line_dsr_n, line_cts_n})));

  assert_loop_state_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    lpbk_en |=> (stat_q[7:4] == $past({ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts})));

  assert_cts_flag_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stat_q[0]) |-> !$stable(stat_q[4]));

  assert_dsr_flag_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stat_q[1]) |-> !$stable(stat_q[5]));

  assert_ring_rise_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stat_q[2]) |-> $rose(stat_q[6]));

  assert_dcd_flag_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(stat_q[3]) |-> !$stable(stat_q[7]));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq == (irq_en && (stat_q[3:0] != 4'h0)));
endmodule

bind modem_stat_reg msr_checker u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .line_cts_n (line_cts_n),
  .line_dsr_n (line_dsr_n),
  .line_ri_n  (line_ri_n),
  .line_dcd_n (line_dcd_n),
  .lpbk_en    (lpbk_en),
  .ctl_rts    (ctl_rts),
  .ctl_dtr    (ctl_dtr),
  .ctl_aux1   (ctl_aux1),
  .ctl_aux2   (ctl_aux2),
  .stat_rd    (stat_rd),
  .irq_en     (irq_en),
  .stat_q     (stat_q),
  .irq        (irq)
);

// File: tb/modem_stat_reg_test.sv
`timescale 1ns/1ps
module modem_stat_reg_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_cts_n, line_dsr_n, line_ri_n, line_dcd_n;
  logic       lpbk_en, ctl_rts, ctl_dtr, ctl_aux1, ctl_aux2;
  logic       stat_rd, irq_en;
  logic [7:0] stat_q;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] m_state = 4'h0;
  logic [3:0] m_flags = 4'h0;

  always #2 clk = ~clk;

  modem_stat_reg uut (
    .clk(clk), .rst_n(rst_n),
    .line_cts_n(line_cts_n), .line_dsr_n(line_dsr_n),
    .line_ri_n(line_ri_n), .line_dcd_n(line_dcd_n),
    .lpbk_en(lpbk_en), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
    .ctl_aux1(ctl_aux1), .ctl_aux2(ctl_aux2),
    .stat_rd(stat_rd), .irq_en(irq_en),
    .stat_q(stat_q), .irq(irq)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual irq/stat=%b/%h expected %b/%h", tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // pins_n = {dcd, ri, dsr, cts}; ctl = {aux2, aux1, dtr, rts}
  task automatic step(input string tag, input logic [3:0] pins_n, input logic loop,
                      input logic [3:0] ctl, input logic rd, input logic en);
    logic [3:0] sel, ev;
    @(negedge clk);
    {line_dcd_n, line_ri_n, line_dsr_n, line_cts_n} = pins_n;
    {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts} = ctl;
    lpbk_en = loop; stat_rd = rd; irq_en = en;
    sel = loop ? ctl : ~pins_n;
    ev[0] = sel[0] ^ m_state[0];
    ev[1] = sel[1] ^ m_state[1];
    ev[2] = sel[2] & ~m_state[2];
    ev[3] = sel[3] ^ m_state[3];
    m_flags = (m_flags & ~{4{rd}}) | ev;
    m_state = sel;
    exp_q.push_back({en & (|m_flags), m_state, m_flags});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), {irq, stat_q}, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    {line_dcd_n, line_ri_n, line_dsr_n, line_cts_n} = 4'hF;
    {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts} = 4'h0;
    lpbk_en = 1'b0; stat_rd = 1'b0; irq_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R9 reset", {irq, stat_q}, 9'h000);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R9 after release", {irq, stat_q}, 9'h000);

    step("R9 idle",         4'hF, 0, 4'h0, 0, 1);
    step("R1 R3 cts",       4'hE, 0, 4'h0, 0, 1);  // irq R8
    step("R6 hold",         4'hE, 0, 4'h0, 0, 1);
    step("R8 enable off",   4'hE, 0, 4'h0, 0, 0);
    step("R6 read",         4'hE, 0, 4'h0, 1, 1);
    step("R6 cleared",      4'hE, 0, 4'h0, 0, 1);
    step("R3 dsr",          4'hC, 0, 4'h0, 0, 1);
    step("R3 cts release",  4'hD, 0, 4'h0, 1, 1);  // R7 event in read cycle
    step("R7 kept",         4'hD, 0, 4'h0, 1, 1);
    step("R4 ring rise",    4'h9, 0, 4'h0, 0, 1);
    step("R4 hold",         4'h9, 0, 4'h0, 1, 1);
    step("R4 ring fall",    4'hD, 0, 4'h0, 0, 1);
    step("R4 no flag",      4'hD, 0, 4'h0, 0, 1);
    step("R5 dcd assert",   4'h5, 0, 4'h0, 1, 1);
    step("R5 cleared",      4'h5, 0, 4'h0, 1, 1);
    step("R5 dcd release",  4'hD, 0, 4'h0, 0, 1);
    step("R7 ring read",    4'h9, 0, 4'h0, 1, 1);
    step("R6 clear all",    4'hF, 0, 4'h0, 1, 1);
    step("R6 idle",         4'hF, 0, 4'h0, 1, 0);
    step("R2 R10 enter",    4'h0, 1, 4'h5, 0, 1);
    step("R2 loop read",    4'h0, 1, 4'h5, 1, 1);
    step("R2 ctl swap",     4'hF, 1, 4'hA, 1, 1);
    step("R2 loop all",     4'hF, 1, 4'hF, 1, 1);
    step("R10 leave",       4'h3, 0, 4'hF, 1, 1);
    step("R1 pins again",   4'h3, 0, 4'h0, 1, 1);
    step("R1 pins idle",    4'hF, 0, 4'h0, 0, 1);
    step("R8 irq off",      4'hF, 0, 4'h0, 0, 0);

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule